// File: doc/BRIEF.md
# Programmable receive frame parser

This block classifies received Ethernet frames against a small table of rules. Frame data arrives as a stream of 32-bit beats. The first beat carries a start-of-frame flag and the last carries an end-of-frame flag. Each rule looks at one 32-bit word of the frame, picked by its word offset, and compares it with stored data. Only the bits set in a per-rule enable mask take part. When a rule fires, it either drops the frame or accepts it and tags it with a DMA channel number. A field that does not sit on a 4-byte boundary is covered by two rules: a head rule, and a continuation rule in the slot right after it. The head's action applies only when both rules match. The last slot of the table is fixed as a catch-all accept rule on channel 0, so every frame gets a decision.

The table is loaded through a single-cycle write port that has one field per rule attribute. Words are compared as they stream in, and each rule keeps a record of whether its word arrived and whether that word matched. The control path is a three-state machine:
- `S_IDLE` waits for a start beat. The transition start→parse is taken on a start beat. The transition start→done is taken on a one-word frame.
- `S_PARSE` takes the following beats. The transition parse→done is taken on the end beat or on the beat at the last parseable word.
- `S_DONE` presents the decision for one cycle. The transition done→idle is always taken.

The parseable depth is 64, 128 or 256 bytes, chosen by the parameter `DEPTH_CODE` = 0, 1 or 2. That gives `16 << DEPTH_CODE` words.

Top module: `frp_top`

## Requirements
- R1: After reset `dec_vld` is low, and every slot except the last is disabled. The first frame after reset is therefore accepted on channel 0.
- R2: An enabled rule matches when `(frame_word & cfg_mask) == (cfg_data & cfg_mask)` for the word at its offset. `cfg_off` is the word offset, where word 0 is the start beat. An all-zero mask matches any word at that offset.
- R3: Rules are scanned in ascending slot index, and the lowest-indexed rule that fully matches decides.
- R4: A deciding rule with `cfg_rej`=1 gives `dec_acc`=0. A deciding rule with `cfg_acc`=1 gives `dec_acc`=1 and `dec_chan` set to its channel.
- R5: A rule written with `cfg_cont`=1 is a continuation. It never decides on its own. The rule in the slot just below it decides only if both rules match, and that lower rule's action is used.
- R6: A rule whose offset is at or beyond the length of a short frame does not match, even with a zero mask.
- R7: `dec_vld` is high for exactly one cycle. That cycle is the one after the end beat, or the one after the beat at word `16<<DEPTH_CODE`-1, whichever comes first. Later beats without a start flag are ignored.
- R8: Table writes made while a frame is being parsed or its decision is out (`S_PARSE`, `S_DONE`) are ignored.
- R9: A write is ignored if it targets the last slot, if its offset is ≥ `16<<DEPTH_CODE`, or if it is enabled with both or neither of `cfg_acc`/`cfg_rej` set.
- R10: The last slot always matches: zero mask, accept, channel 0, offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Beat valid |
| in_sof | input | 1 | Beat is word 0 of a frame |
| in_eof | input | 1 | Beat is the last word of a frame |
| in_word | input | 32 | Frame word |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | $clog2(N_ENT) | Slot written |
| cfg_en | input | 1 | Rule enabled |
| cfg_off | input | 6 | Word offset compared |
| cfg_mask | input | 32 | Per-bit compare enable |
| cfg_data | input | 32 | Compare data |
| cfg_acc | input | 1 | Accept action |
| cfg_rej | input | 1 | Drop action |
| cfg_cont | input | 1 | Rule continues the slot below |
| cfg_chan | input | CHAN_W | DMA channel for accept |
| dec_vld | output | 1 | Decision valid (one cycle) |
| dec_acc | output | 1 | 1 = forward, 0 = drop |
| dec_chan | output | CHAN_W | Channel of the forwarded frame |

## Verification
The hardest case to create from the ports is a chained pair where only one half matches. In particular, the continuation can match while its head does not, which must not look like a decision. The stimulus loads a head/continuation pair at adjacent offsets. It then sends frames that match both halves, only the head, and only the continuation. A second hard case is a table write that lands mid-frame. The frame task raises the write strobe on a chosen beat, and the frames that follow show whether the table changed.

// File: rtl/frp_pkg.sv
package frp_pkg;
    localparam int OFF_W = 6;

    typedef enum logic [1:0] {S_IDLE, S_PARSE, S_DONE} st_t;

    typedef struct packed {
        logic              en;
        logic              acc;
        logic              rej;
        logic              cont;
        logic [OFF_W-1:0]  off;
        logic [31:0]       mask;
        logic [31:0]       data;
    } rule_t;
endpackage

// File: rtl/frp_table.sv
module frp_table
    import frp_pkg::*;
#(
    parameter int N_ENT     = 16,
    parameter int CHAN_W    = 3,
    parameter int MAX_WORDS = 16,
    localparam int IW       = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              we,
    input  logic [IW-1:0]     idx,
    input  rule_t             wr_rule,
    input  logic [CHAN_W-1:0] wr_chan,
    output rule_t             rules [N_ENT],
    output logic [CHAN_W-1:0] chans [N_ENT]
);
    logic legal;

    always_comb begin
        legal = we && wr_ok && (32'(idx) != N_ENT - 1)
                && (32'(wr_rule.off) < MAX_WORDS)
                && !(wr_rule.en && (wr_rule.acc == wr_rule.rej));
    end

    for (genvar i = 0; i < N_ENT - 1; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rules[i] <= '0;
                chans[i] <= '0;
            end else if (legal && idx == IW'(i)) begin
                rules[i] <= wr_rule;
                chans[i] <= wr_chan;
            end
        end

        // R8: nothing changes while parsing
        p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_ok |=> $stable(rules[i]));
        // R9: an enabled rule carries exactly one action
        p_one_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
            rules[i].en |-> (rules[i].acc != rules[i].rej));
    end

    assign rules[N_ENT-1] = '{en: 1'b1, acc: 1'b1, rej: 1'b0, cont: 1'b0,
                              off: '0, mask: '0, data: '0};
    assign chans[N_ENT-1] = '0;
endmodule

// File: rtl/frp_match.sv
module frp_match
    import frp_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [OFF_W-1:0] widx,
    input  logic [31:0]      word,
    input  rule_t            rules [N_ENT],
    output logic [N_ENT-1:0] hit
);
    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        logic seen_q, ok_q, here, same;

        always_comb begin
            here = (rules[i].off == widx);
            same = ((word ^ rules[i].data) & rules[i].mask) == 32'd0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen_q <= 1'b0;
                ok_q   <= 1'b0;
            end else if (start) begin
                seen_q <= here;
                ok_q   <= same;
            end else if (step && here) begin
                seen_q <= 1'b1;
                ok_q   <= same;
            end
        end

        assign hit[i] = seen_q && ok_q && rules[i].en;
    end

    // R10: the catch-all slot matches every frame
    p_catch_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> hit[N_ENT-1]);
endmodule

// File: rtl/frp_pick.sv
module frp_pick
    import frp_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int CHAN_W = 3
) (
    input  rule_t             rules [N_ENT],
    input  logic [CHAN_W-1:0] chans [N_ENT],
    input  logic [N_ENT-1:0]  hit,
    output logic              acc,
    output logic [CHAN_W-1:0] chan
);
    logic [N_ENT-1:0] fires;

    for (genvar i = 0; i < N_ENT; i++) begin : g_fire
        if (i < N_ENT - 1) begin : g_pair
            assign fires[i] = hit[i] && !rules[i].cont &&
                (!(rules[i+1].en && rules[i+1].cont) || hit[i+1]);
        end else begin : g_tail
            assign fires[i] = hit[i] && !rules[i].cont;
        end
    end

    always_comb begin
        acc  = 1'b1;
        chan = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (fires[i]) begin
                acc  = rules[i].acc;
                chan = chans[i];
            end
        end
    end
endmodule

// File: rtl/frp_top.sv
module frp_top
    import frp_pkg::*;
#(
    parameter int N_ENT      = 16,
    parameter int CHAN_W     = 3,
    parameter int DEPTH_CODE = 0,
    localparam int IW        = $clog2(N_ENT),
    localparam int MAX_WORDS = 16 << DEPTH_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [31:0]       in_word,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_idx,
    input  logic              cfg_en,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic [31:0]       cfg_mask,
    input  logic [31:0]       cfg_data,
    input  logic              cfg_acc,
    input  logic              cfg_rej,
    input  logic              cfg_cont,
    input  logic [CHAN_W-1:0] cfg_chan,
    output logic              dec_vld,
    output logic              dec_acc,
    output logic [CHAN_W-1:0] dec_chan
);
    st_t               state_q, state_d;
    logic [OFF_W-1:0]  widx_q;
    logic              start, step, at_limit;
    logic [OFF_W-1:0]  cur_idx;
    rule_t             wr_rule;
    rule_t             rules [N_ENT];
    logic [CHAN_W-1:0] chans [N_ENT];
    logic [N_ENT-1:0]  hit;
    logic              pick_acc;
    logic [CHAN_W-1:0] pick_chan;

    assign start    = (state_q == S_IDLE) && in_vld && in_sof;
    assign step     = (state_q == S_PARSE) && in_vld;
    assign at_limit = (32'(widx_q) == MAX_WORDS - 1);
    assign cur_idx  = start ? '0 : widx_q;
    assign wr_rule  = '{en: cfg_en, acc: cfg_acc, rej: cfg_rej, cont: cfg_cont,
                        off: cfg_off, mask: cfg_mask, data: cfg_data};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = (in_eof || MAX_WORDS == 1) ? S_DONE : S_PARSE;
            S_PARSE: if (step && (in_eof || at_limit)) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            widx_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start)     widx_q <= OFF_W'(1);
            else if (step) widx_q <= widx_q + OFF_W'(1);
        end
    end

    always_comb begin
        dec_vld  = (state_q == S_DONE);
        dec_acc  = dec_vld && pick_acc;
        dec_chan = dec_vld ? pick_chan : '0;
    end

    frp_table #(.N_ENT(N_ENT), .CHAN_W(CHAN_W), .MAX_WORDS(MAX_WORDS)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_ok(state_q == S_IDLE), .we(cfg_we),
        .idx(cfg_idx), .wr_rule(wr_rule), .wr_chan(cfg_chan),
        .rules(rules), .chans(chans));

    frp_match #(.N_ENT(N_ENT)) u_match (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step), .widx(cur_idx),
        .word(in_word), .rules(rules), .hit(hit));

    frp_pick #(.N_ENT(N_ENT), .CHAN_W(CHAN_W)) u_pick (
        .rules(rules), .chans(chans), .hit(hit), .acc(pick_acc), .chan(pick_chan));

    // R7: decision is a single-cycle pulse
    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld);
    // R7: end beat is followed by the decision
    p_eof_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && in_eof) |=> dec_vld);
    // R7: depth limit forces the decision
    p_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_limit) |=> dec_vld);
endmodule

// File: tb/sim_frp_top.sv
module sim_frp_top;
    localparam int N    = 16;
    localparam int CW   = 3;
    localparam int MAXW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_vld = 0, in_sof = 0, in_eof = 0;
    logic [31:0] in_word = '0;
    logic cfg_we = 0, cfg_en = 0, cfg_acc = 0, cfg_rej = 0, cfg_cont = 0;
    logic [3:0] cfg_idx = '0;
    logic [5:0] cfg_off = '0;
    logic [31:0] cfg_mask = '0, cfg_data = '0;
    logic [CW-1:0] cfg_chan = '0;
    logic dec_vld, dec_acc;
    logic [CW-1:0] dec_chan;

    always #2 clk = ~clk;

    frp_top #(.N_ENT(N), .CHAN_W(CW), .DEPTH_CODE(0)) u0 (.*);

    int n_tests = 0, n_fail = 0;
    string cur_req = "R1";

    // reference model state
    bit        m_en [N], m_acc [N], m_rej [N], m_cont [N];
    int        m_off [N], m_chan [N];
    bit [31:0] m_mask [N], m_data [N];
    int        m_state = 0;
    bit [31:0] words [$];
    bit        exp_vld = 0, exp_acc = 0;
    int        exp_chan = 0;

    function automatic bit rule_hit(int i);
        if (!m_en[i] || m_off[i] >= words.size()) return 0;
        return ((words[m_off[i]] ^ m_data[i]) & m_mask[i]) == 0;
    endfunction

    function automatic void decide();
        for (int i = 0; i < N; i++) begin
            bit ok;
            if (!m_en[i] || m_cont[i]) continue;
            ok = rule_hit(i);
            if (i + 1 < N && m_en[i+1] && m_cont[i+1]) ok = ok && rule_hit(i + 1);
            if (ok) begin
                exp_acc  = m_acc[i];
                exp_chan = m_acc[i] ? m_chan[i] : 0;
                return;
            end
        end
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_en[i] = 0; m_acc[i] = 0; m_rej[i] = 0; m_cont[i] = 0;
            m_off[i] = 0; m_chan[i] = 0; m_mask[i] = 0; m_data[i] = 0;
        end
        m_en[N-1] = 1; m_acc[N-1] = 1;
        m_state = 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            case (m_state)
                0: begin
                    if (cfg_we && cfg_idx != N - 1 && cfg_off < MAXW &&
                        !(cfg_en && cfg_acc == cfg_rej)) begin
                        m_en[cfg_idx] = cfg_en; m_acc[cfg_idx] = cfg_acc;
                        m_rej[cfg_idx] = cfg_rej; m_cont[cfg_idx] = cfg_cont;
                        m_off[cfg_idx] = cfg_off; m_mask[cfg_idx] = cfg_mask;
                        m_data[cfg_idx] = cfg_data; m_chan[cfg_idx] = cfg_chan;
                    end
                    if (in_vld && in_sof) begin
                        words = {};
                        words.push_back(in_word);
                        if (in_eof) begin m_state = 2; decide(); end
                        else m_state = 1;
                    end
                end
                1: if (in_vld) begin
                    words.push_back(in_word);
                    if (in_eof || words.size() == MAXW) begin m_state = 2; decide(); end
                end
                default: m_state = 0;
            endcase
        end
        exp_vld = (m_state == 2);
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (dec_vld !== exp_vld ||
                (exp_vld && (dec_acc !== exp_acc || (exp_acc && dec_chan !== CW'(exp_chan))))) begin
                n_fail++;
                $display("FAIL %s: vld/acc/chan actual %b/%b/%0d expected %b/%b/%0d",
                         cur_req, dec_vld, dec_acc, dec_chan, exp_vld, exp_acc, exp_chan);
            end
        end
    end

    bit [31:0] fw [32];

    task automatic wr(int idx, bit en, int off, bit [31:0] mask, bit [31:0] data,
                      bit acc, bit rej, bit cont, int chan);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 4'(idx); cfg_en = en; cfg_off = 6'(off);
        cfg_mask = mask; cfg_data = data; cfg_acc = acc; cfg_rej = rej;
        cfg_cont = cont; cfg_chan = CW'(chan);
    endtask

    task automatic wr_end();
        @(negedge clk);
        cfg_we = 0;
    endtask

    // send n words from fw; the preset write strobe fires on beat wr_at
    task automatic frame(int n, int wr_at);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_vld = 1; in_sof = (k == 0); in_eof = (k == n - 1);
            in_word = fw[k]; cfg_we = (k == wr_at);
        end
        @(negedge clk);
        in_vld = 0; in_sof = 0; in_eof = 0; cfg_we = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic fill(bit [31:0] seed);
        for (int k = 0; k < 32; k++) fw[k] = seed + 32'(k) * 32'h01010101;
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, idle output and empty table
        @(negedge clk);
        n_tests++;
        if (dec_vld !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: dec_vld actual %b expected 0", dec_vld);
        end
        cur_req = "R1"; fill(32'h10000000); frame(3, -1);
        // R10: no user rule, pass-all on channel 0
        cur_req = "R10"; fill(32'h20000000); frame(1, -1);

        // R2/R4: masked compare on word 1, accept to channel 5
        wr(0, 1, 1, 32'hFFFF0000, 32'hABCD0000, 1, 0, 0, 5); wr_end();
        cur_req = "R2"; fill(0); fw[1] = 32'hABCD1234; frame(4, -1);
        cur_req = "R2"; fw[1] = 32'hABCE1234; frame(4, -1);
        // R4: reject rule on word 0 low byte
        wr(1, 1, 0, 32'h000000FF, 32'h00000011, 0, 1, 0, 0); wr_end();
        cur_req = "R4"; fill(0); fw[0] = 32'h99999911; frame(3, -1);
        // R3: both match, lower slot wins
        cur_req = "R3"; fw[1] = 32'hABCD0000; frame(3, -1);

        // R5: chained pair in slots 3/4
        wr(3, 1, 2, 32'hFFFF0000, 32'h55660000, 1, 0, 0, 6); wr_end();
        wr(4, 1, 3, 32'h0000FFFF, 32'h00007788, 1, 0, 1, 1); wr_end();
        cur_req = "R5"; fill(0); fw[2] = 32'h55661111; fw[3] = 32'h22227788; frame(5, -1);
        cur_req = "R5"; fw[3] = 32'h22227789; frame(5, -1);
        cur_req = "R5"; fw[2] = 32'h55671111; fw[3] = 32'h22227788; frame(5, -1);

        // R6: zero-mask reject at word 10 only hits long frames
        wr(5, 1, 10, 32'h0, 32'h0, 0, 1, 0, 0); wr_end();
        cur_req = "R6"; fill(32'h30000000); frame(4, -1);
        cur_req = "R6"; frame(10, -1);
        cur_req = "R6"; frame(12, -1);

        // R7: decision at depth limit, trailing beats ignored
        cur_req = "R7"; fill(32'h40000000); frame(20, -1);
        cur_req = "R7"; frame(16, -1);

        // R8: write raised mid-frame must not land
        cur_req = "R8"; fill(32'h50000000);
        cfg_idx = 4'd7; cfg_en = 1; cfg_off = 0; cfg_mask = 0; cfg_data = 0;
        cfg_acc = 0; cfg_rej = 1; cfg_cont = 0; cfg_chan = 0;
        frame(4, 2);
        frame(3, -1);

        // R9: illegal writes are dropped
        cur_req = "R9";
        wr(8, 1, 20, 32'h0, 32'h0, 0, 1, 0, 0); wr_end();
        wr(8, 1, 0, 32'h0, 32'h0, 1, 1, 0, 2); wr_end();
        wr(8, 1, 0, 32'h0, 32'h0, 0, 0, 0, 2); wr_end();
        wr(15, 1, 0, 32'h0, 32'h0, 0, 1, 0, 0); wr_end();
        fill(32'h60000000); frame(3, -1);
        // R9/R4: legal accept on slot 8 channel 7
        wr(8, 1, 0, 32'h0, 32'h0, 1, 0, 0, 7); wr_end();
        cur_req = "R4"; frame(3, -1);

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule